// File: doc/BRIEF.md
# Scatter-Gather Memory-to-Stream Engine

This engine walks a chain of buffer descriptors held in memory and sends the bytes that each descriptor points at out of a byte-wide valid/ready stream. A single word-wide master port serves every memory access. The engine uses it to fetch descriptor words, to read buffer data, and to write a completion status back into each descriptor it finishes. Frames can span several descriptors. A start-of-frame flag opens a frame, and an end-of-frame flag closes it with a last beat and a one-cycle completion pulse.

The surrounding logic supplies the head descriptor address, the tail descriptor address and a run level, and then pulses start. The engine reports through an idle flag, which is high whenever no walk is in progress. Every descriptor is 64 bytes long and is laid out little-endian. Only the low 32-bit word of each 64-bit pointer is used.

Top module: `sg_m2s_engine`

## Requirements
- R1: After reset, idle is 1, and m_tvalid, mem_req and frame_done are all 0.
- R2: When idle is 1, a start pulse with run=1 clears idle and begins a walk at cur_desc, with tail_desc as the tail. A start pulse with run=0 is ignored: no memory access occurs and idle stays 1.
- R3: The engine reads each descriptor's status word first, at byte offset 0x1C. If bit 31 of that word is already set, the engine sets idle and stops, with no data beats and no write to that descriptor.
- R4: The engine reads the control word at offset 0x18 (length in bits 22:0) and the buffer address at offset 0x08. It then emits exactly that many bytes, one per accepted beat, in rising byte-address order. Byte k of a 32-bit word sits in bits 8k+7:8k, and the buffer may start at any byte alignment.
- R5: m_tlast is 1 only on the final byte of a descriptor whose control bit 26 (end of frame) is set.
- R6: After a descriptor's bytes have been sent, the engine writes 0x80000000 ORed with the control length into its status word at offset 0x1C.
- R7: The engine then takes the next pointer, read from offset 0x00, as the current descriptor. If the finished descriptor is the tail, the engine sets idle and stops, and later descriptors in the chain are not touched.
- R8: On a descriptor with control bit 27 (start of frame) set, the frame byte count restarts at 0 and the six application words at offsets 0x20+4i are captured into frame_app bits 32i+31:32i. Completing a descriptor with end of frame set raises frame_done for exactly one cycle, with frame_len equal to the bytes sent since the last start of frame.
- R9: If run is 0 when a descriptor's status is fetched, the engine sets idle and stops before that descriptor is processed.
- R10: While mem_req is 1 and mem_ack is 0, mem_req, mem_addr, mem_we and mem_wdata hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Engine enabled |
| start | input | 1 | Begin a walk (one-cycle pulse) |
| cur_desc | input | AW | Address of the first descriptor |
| tail_desc | input | AW | Address of the last descriptor |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access accepted; read data valid this cycle |
| mem_rdata | input | 32 | Read data |
| m_tvalid | output | 1 | Stream byte valid |
| m_tready | input | 1 | Stream sink ready |
| m_tdata | output | 8 | Stream byte |
| m_tlast | output | 1 | Last byte of a frame |
| idle | output | 1 | No walk in progress |
| frame_done | output | 1 | One-cycle pulse per finished frame |
| frame_len | output | FLEN_W | Byte count of the frame just finished |
| frame_app | output | APP_N*32 | Application words captured at start of frame |

## Verification
The tests use single aligned descriptors to confirm the basic fetch, send and write-back sequence. Chains with unaligned buffers of odd length separate correct byte-lane stepping from off-by-one errors in the lane and length arithmetic. Chains that end early at the tail, or that meet an already-completed descriptor, show whether the engine stops at the right point, which appears in the untouched status words. Dropping run in the middle of a walk, and random chains under random stream and memory stalls, show that back-pressure never loses, repeats or reorders a byte.

// File: rtl/sg_m2s_pkg.sv
package sg_m2s_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RSTAT,
    ST_RCTRL,
    ST_RNEXT,
    ST_RBUF,
    ST_RAPP,
    ST_RDAT,
    ST_SEND,
    ST_WB,
    ST_ADV
  } walk_st_e;

  // descriptor byte offsets
  localparam int unsigned OFS_NEXT = 0;
  localparam int unsigned OFS_BUF  = 8;
  localparam int unsigned OFS_CTRL = 24;
  localparam int unsigned OFS_STAT = 28;
  localparam int unsigned OFS_APP  = 32;

  // control and status bit positions
  localparam int unsigned CTL_EOF   = 26;
  localparam int unsigned CTL_SOF   = 27;
  localparam int unsigned STAT_DONE = 31;

endpackage

// File: rtl/sg_m2s_lane.sv
module sg_m2s_lane (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld,
  input  logic [31:0] word,
  input  logic [1:0]  ofs,
  input  logic [2:0]  cnt,
  input  logic        last_in,
  input  logic        m_tready,
  output logic        m_tvalid,
  output logic [7:0]  m_tdata,
  output logic        m_tlast,
  output logic        busy
);

  logic [31:0] wbuf_q, wbuf_d;
  logic [1:0]  lane_q, lane_d;
  logic [2:0]  rem_q, rem_d;
  logic        lastf_q, lastf_d;
  logic        en;

  always_comb begin
    wbuf_d  = wbuf_q;
    lane_d  = lane_q;
    rem_d   = rem_q;
    lastf_d = lastf_q;
    en      = 1'b0;
    if (ld) begin
      wbuf_d  = word;
      lane_d  = ofs;
      rem_d   = cnt;
      lastf_d = last_in;
      en      = 1'b1;
    end else if (m_tvalid && m_tready) begin
      lane_d = lane_q + 2'd1;
      rem_d  = rem_q - 3'd1;
      en     = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbuf_q  <= '0;
      lane_q  <= '0;
      rem_q   <= '0;
      lastf_q <= 1'b0;
    end else if (en) begin
      wbuf_q  <= wbuf_d;
      lane_q  <= lane_d;
      rem_q   <= rem_d;
      lastf_q <= lastf_d;
    end
  end

  assign m_tvalid = (rem_q != 3'd0);
  assign m_tdata  = wbuf_q[8*lane_q +: 8];
  assign m_tlast  = lastf_q && (rem_q == 3'd1);
  assign busy     = m_tvalid;

endmodule

// File: rtl/sg_m2s_seq.sv
module sg_m2s_seq
  import sg_m2s_pkg::*;
#(
  parameter int AW     = 32,
  parameter int LEN_W  = 23,
  parameter int APP_N  = 6,
  parameter int FLEN_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                start,
  input  logic [AW-1:0]       cur_in,
  input  logic [AW-1:0]       tail_in,
  output logic                mem_req,
  output logic                mem_we,
  output logic [AW-1:0]       mem_addr,
  output logic [31:0]         mem_wdata,
  input  logic                mem_ack,
  input  logic [31:0]         mem_rdata,
  output logic                lane_ld,
  output logic [1:0]          lane_ofs,
  output logic [2:0]          lane_cnt,
  output logic                lane_last,
  input  logic                lane_busy,
  output logic                idle,
  output logic                frame_done,
  output logic [FLEN_W-1:0]   frame_len,
  output logic [APP_N*32-1:0] frame_app
);

  localparam int AIDX_W = (APP_N > 1) ? $clog2(APP_N) : 1;

  walk_st_e st_q, st_d;
  logic [AW-1:0]     cur_q, cur_d, tail_q, tail_d, nxt_q, nxt_d, bptr_q, bptr_d;
  logic [LEN_W-1:0]  dlen_q, dlen_d, left_q, left_d;
  logic              eof_q, eof_d, sof_q, sof_d;
  logic [FLEN_W-1:0] fpos_q, fpos_d;
  logic [APP_N-1:0][31:0] app_q, app_d;
  logic [AIDX_W-1:0] idx_q, idx_d;
  logic              idle_q, idle_d, done_q, done_d;
  logic [2:0]        room, take;
  walk_st_e          after_hdr;

  // bytes available from the current word lane onward, clipped to what is left
  always_comb begin
    room = 3'd4 - {1'b0, bptr_q[1:0]};
    take = (left_q < LEN_W'(room)) ? left_q[2:0] : room;
  end

  assign after_hdr = (dlen_q == '0) ? ST_WB : ST_RDAT;

  always_comb begin
    mem_req = 1'b0;
    mem_we  = 1'b0;
    mem_addr = '0;
    unique case (st_q)
      ST_RSTAT: begin mem_req = 1'b1; mem_addr = cur_q + AW'(OFS_STAT); end
      ST_RCTRL: begin mem_req = 1'b1; mem_addr = cur_q + AW'(OFS_CTRL); end
      ST_RNEXT: begin mem_req = 1'b1; mem_addr = cur_q + AW'(OFS_NEXT); end
      ST_RBUF:  begin mem_req = 1'b1; mem_addr = cur_q + AW'(OFS_BUF); end
      ST_RAPP:  begin mem_req = 1'b1; mem_addr = cur_q + AW'(OFS_APP) + (AW'(idx_q) << 2); end
      ST_RDAT:  begin mem_req = 1'b1; mem_addr = {bptr_q[AW-1:2], 2'b00}; end
      ST_WB:    begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = cur_q + AW'(OFS_STAT); end
      default:  ;
    endcase
  end

  assign mem_wdata = (32'd1 << STAT_DONE) | 32'(dlen_q);

  assign lane_ld   = (st_q == ST_RDAT) && mem_ack;
  assign lane_ofs  = bptr_q[1:0];
  assign lane_cnt  = take;
  assign lane_last = eof_q && (LEN_W'(take) == left_q);

  always_comb begin
    st_d   = st_q;
    cur_d  = cur_q;
    tail_d = tail_q;
    nxt_d  = nxt_q;
    bptr_d = bptr_q;
    dlen_d = dlen_q;
    left_d = left_q;
    eof_d  = eof_q;
    sof_d  = sof_q;
    fpos_d = fpos_q;
    app_d  = app_q;
    idx_d  = idx_q;
    idle_d = idle_q;
    done_d = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start && run) begin
        cur_d  = cur_in;
        tail_d = tail_in;
        idle_d = 1'b0;
        st_d   = ST_RSTAT;
      end
      ST_RSTAT: if (mem_ack) begin
        if (mem_rdata[STAT_DONE] || !run) begin
          idle_d = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          st_d = ST_RCTRL;
        end
      end
      ST_RCTRL: if (mem_ack) begin
        dlen_d = mem_rdata[LEN_W-1:0];
        left_d = mem_rdata[LEN_W-1:0];
        eof_d  = mem_rdata[CTL_EOF];
        sof_d  = mem_rdata[CTL_SOF];
        st_d   = ST_RNEXT;
      end
      ST_RNEXT: if (mem_ack) begin
        nxt_d = mem_rdata[AW-1:0];
        st_d  = ST_RBUF;
      end
      ST_RBUF: if (mem_ack) begin
        bptr_d = mem_rdata[AW-1:0];
        if (sof_q) begin
          fpos_d = '0;
          idx_d  = '0;
          st_d   = ST_RAPP;
        end else begin
          st_d = after_hdr;
        end
      end
      ST_RAPP: if (mem_ack) begin
        app_d[idx_q] = mem_rdata;
        if (idx_q == AIDX_W'(APP_N - 1)) st_d = after_hdr;
        else idx_d = idx_q + AIDX_W'(1);
      end
      ST_RDAT: if (mem_ack) begin
        bptr_d = bptr_q + AW'(take);
        left_d = left_q - LEN_W'(take);
        fpos_d = fpos_q + FLEN_W'(take);
        st_d   = ST_SEND;
      end
      ST_SEND: if (!lane_busy) begin
        st_d = (left_q == '0) ? ST_WB : ST_RDAT;
      end
      ST_WB: if (mem_ack) begin
        done_d = eof_q;
        st_d   = ST_ADV;
      end
      ST_ADV: begin
        cur_d = nxt_q;
        if (cur_q == tail_q) begin
          idle_d = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          st_d = ST_RSTAT;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cur_q  <= '0;
      tail_q <= '0;
      nxt_q  <= '0;
      bptr_q <= '0;
      dlen_q <= '0;
      left_q <= '0;
      eof_q  <= 1'b0;
      sof_q  <= 1'b0;
      fpos_q <= '0;
      app_q  <= '0;
      idx_q  <= '0;
      idle_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cur_q  <= cur_d;
      tail_q <= tail_d;
      nxt_q  <= nxt_d;
      bptr_q <= bptr_d;
      dlen_q <= dlen_d;
      left_q <= left_d;
      eof_q  <= eof_d;
      sof_q  <= sof_d;
      fpos_q <= fpos_d;
      app_q  <= app_d;
      idx_q  <= idx_d;
      idle_q <= idle_d;
      done_q <= done_d;
    end
  end

  assign idle       = idle_q;
  assign frame_done = done_q;
  assign frame_len  = fpos_q;
  assign frame_app  = app_q;

endmodule

// File: rtl/sg_m2s_engine.sv
module sg_m2s_engine #(
  parameter int AW     = 32,
  parameter int LEN_W  = 23,
  parameter int APP_N  = 6,
  parameter int FLEN_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                start,
  input  logic [AW-1:0]       cur_desc,
  input  logic [AW-1:0]       tail_desc,
  output logic                mem_req,
  output logic                mem_we,
  output logic [AW-1:0]       mem_addr,
  output logic [31:0]         mem_wdata,
  input  logic                mem_ack,
  input  logic [31:0]         mem_rdata,
  output logic                m_tvalid,
  input  logic                m_tready,
  output logic [7:0]          m_tdata,
  output logic                m_tlast,
  output logic                idle,
  output logic                frame_done,
  output logic [FLEN_W-1:0]   frame_len,
  output logic [APP_N*32-1:0] frame_app
);

  logic       lane_ld, lane_last, lane_busy;
  logic [1:0] lane_ofs;
  logic [2:0] lane_cnt;

  sg_m2s_seq #(
    .AW(AW), .LEN_W(LEN_W), .APP_N(APP_N), .FLEN_W(FLEN_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .start      (start),
    .cur_in     (cur_desc),
    .tail_in    (tail_desc),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .lane_ld    (lane_ld),
    .lane_ofs   (lane_ofs),
    .lane_cnt   (lane_cnt),
    .lane_last  (lane_last),
    .lane_busy  (lane_busy),
    .idle       (idle),
    .frame_done (frame_done),
    .frame_len  (frame_len),
    .frame_app  (frame_app)
  );

  sg_m2s_lane u_lane (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld       (lane_ld),
    .word     (mem_rdata),
    .ofs      (lane_ofs),
    .cnt      (lane_cnt),
    .last_in  (lane_last),
    .m_tready (m_tready),
    .m_tvalid (m_tvalid),
    .m_tdata  (m_tdata),
    .m_tlast  (m_tlast),
    .busy     (lane_busy)
  );

endmodule

// File: rtl/sg_m2s_engine_chk.sv
module sg_m2s_engine_chk #(
  parameter int AW     = 32,
  parameter int LEN_W  = 23,
  parameter int APP_N  = 6,
  parameter int FLEN_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                run,
  input logic                start,
  input logic [AW-1:0]       cur_desc,
  input logic [AW-1:0]       tail_desc,
  input logic                mem_req,
  input logic                mem_we,
  input logic [AW-1:0]       mem_addr,
  input logic [31:0]         mem_wdata,
  input logic                mem_ack,
  input logic [31:0]         mem_rdata,
  input logic                m_tvalid,
  input logic                m_tready,
  input logic [7:0]          m_tdata,
  input logic                m_tlast,
  input logic                idle,
  input logic                frame_done,
  input logic [FLEN_W-1:0]   frame_len,
  input logic [APP_N*32-1:0] frame_app
);

  // an idle engine makes no access and offers no beat
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !mem_req && !m_tvalid);

  p_start_walk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    idle && start && run |=> !idle);

  p_beat_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tlast));

  p_wb_done_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[31]);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                            && $stable(mem_wdata));

endmodule

bind sg_m2s_engine sg_m2s_engine_chk #(
  .AW(AW), .LEN_W(LEN_W), .APP_N(APP_N), .FLEN_W(FLEN_W)
) u_chk (.*);

// File: tb/test_sg_m2s_engine.sv
module test_sg_m2s_engine;

  localparam int AW = 32, LEN_W = 23, APP_N = 6, FLEN_W = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, run, start, mem_req, mem_we, mem_ack;
  logic [AW-1:0] cur_desc, tail_desc, mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic m_tvalid, m_tready, m_tlast, idle, frame_done;
  logic [7:0] m_tdata;
  logic [FLEN_W-1:0] frame_len;
  logic [APP_N*32-1:0] frame_app;

  sg_m2s_engine #(.AW(AW), .LEN_W(LEN_W), .APP_N(APP_N), .FLEN_W(FLEN_W)) i_sg_m2s_engine (.*);

  int n_chk = 0, n_err = 0;
  bit full_ready = 1'b1;

  logic [31:0] mem [0:1023];

  // memory responder with random wait states
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
    end else if (mem_req && mem_ack) begin
      mem_ack <= 1'b0;
      if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
    end else if (mem_req && ($urandom_range(3) != 0)) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[mem_addr[11:2]];
    end
  end

  always @(negedge clk) m_tready <= full_ready ? 1'b1 : ($urandom_range(2) != 0);

  // stream and frame capture
  logic [7:0]  rx_b [0:8191];
  logic        rx_l [0:8191];
  int          rx_n;
  logic [31:0] fr_len [0:255];
  logic [31:0] fr_a0 [0:255];
  logic [31:0] fr_a5 [0:255];
  int          fr_n;
  always @(posedge clk) begin
    if (!rst_n) begin
      rx_n <= 0;
      fr_n <= 0;
    end else begin
      if (m_tvalid && m_tready) begin
        rx_b[rx_n] <= m_tdata;
        rx_l[rx_n] <= m_tlast;
        rx_n <= rx_n + 1;
      end
      if (frame_done) begin
        fr_len[fr_n] <= frame_len;
        fr_a0[fr_n]  <= frame_app[31:0];
        fr_a5[fr_n]  <= frame_app[32*5 +: 32];
        fr_n <= fr_n + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    #(8 * 150000);
    n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  function automatic logic [7:0] gb(input int a);
    logic [31:0] w;
    w = mem[(a >> 2) & 1023];
    return w[8*(a & 3) +: 8];
  endfunction

  task automatic put_desc(input int k, input int nk, input int buf_a, input int len,
                          input bit sof, input bit eof, input bit done);
    mem[k*16 + 0] = 64 * nk;
    mem[k*16 + 1] = 32'h0;
    mem[k*16 + 2] = buf_a;
    mem[k*16 + 3] = 32'h0;
    mem[k*16 + 4] = 32'h0;
    mem[k*16 + 5] = 32'h0;
    mem[k*16 + 6] = (32'(eof) << 26) | (32'(sof) << 27) | (len & 32'h7fffff);
    mem[k*16 + 7] = done ? 32'h8000_0000 : 32'h0;
    for (int i = 0; i < 6; i++) mem[k*16 + 8 + i] = $urandom;
  endtask

  // bench model state
  logic [7:0]  exp_b [0:8191];
  bit          exp_l [0:8191];
  int          exp_n, exp_f;
  logic [31:0] exp_flen [0:255];
  logic [31:0] exp_a0 [0:255];
  logic [31:0] exp_a5 [0:255];
  logic [31:0] exp_st [0:15];
  logic [31:0] m_pos = 0, m_a0 = 0, m_a5 = 0;

  task automatic model(input int cur, input int tail);
    int c, len;
    logic [31:0] ctl, b;
    exp_n = 0;
    exp_f = 0;
    for (int k = 0; k < 16; k++) exp_st[k] = mem[k*16 + 7];
    c = cur;
    for (int guard = 0; guard < 32; guard++) begin
      if (mem[(c + 28) >> 2][31]) break;
      ctl = mem[(c + 24) >> 2];
      len = int'(ctl[22:0]);
      b   = mem[(c + 8) >> 2];
      if (ctl[27]) begin
        m_pos = 0;
        m_a0  = mem[(c + 32) >> 2];
        m_a5  = mem[(c + 52) >> 2];
      end
      for (int i = 0; i < len; i++) begin
        exp_b[exp_n] = gb(int'(b) + i);
        exp_l[exp_n] = ctl[26] && (i == len - 1);
        exp_n++;
      end
      m_pos += len;
      if (ctl[26]) begin
        exp_flen[exp_f] = m_pos;
        exp_a0[exp_f]   = m_a0;
        exp_a5[exp_f]   = m_a5;
        exp_f++;
      end
      exp_st[c / 64] = 32'h8000_0000 | len;
      if (c == tail) break;
      c = int'(mem[c >> 2]);
    end
  endtask

  task automatic pulse_start(input int cur, input int tail);
    @(negedge clk);
    cur_desc  = cur;
    tail_desc = tail;
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int t = 0; t < 20000 && !idle; t++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // model_tail: where the walk is expected to end; drop: lower run after first beat
  task automatic run_walk(input int cur_k, input int tail_k, input int model_tail_k,
                          input bit drop, input string tag);
    int n0, f0, bad_b, bad_l, bad_f, bad_s;
    model(cur_k * 64, model_tail_k * 64);
    n0 = rx_n;
    f0 = fr_n;
    pulse_start(cur_k * 64, tail_k * 64);
    if (drop) begin
      for (int t = 0; t < 20000 && rx_n == n0; t++) @(negedge clk);
      run = 1'b0;
    end
    wait_idle();
    run = 1'b1;
    bad_b = 0; bad_l = 0; bad_f = 0; bad_s = 0;
    chk(rx_n - n0 == exp_n, {tag, " R4 beat count"}, rx_n - n0, exp_n);
    for (int i = 0; i < exp_n && i < rx_n - n0; i++) begin
      if (rx_b[n0 + i] !== exp_b[i]) bad_b++;
      if (rx_l[n0 + i] !== exp_l[i]) bad_l++;
    end
    chk(bad_b == 0, {tag, " R4 byte order (mismatches)"}, bad_b, 0);
    chk(bad_l == 0, {tag, " R5 last flag (mismatches)"}, bad_l, 0);
    chk(fr_n - f0 == exp_f, {tag, " R8 frame count"}, fr_n - f0, exp_f);
    for (int i = 0; i < exp_f && i < fr_n - f0; i++)
      if (fr_len[f0 + i] !== exp_flen[i] || fr_a0[f0 + i] !== exp_a0[i] ||
          fr_a5[f0 + i] !== exp_a5[i]) bad_f++;
    chk(bad_f == 0, {tag, " R8 frame length/app words (mismatches)"}, bad_f, 0);
    for (int k = 0; k < 16; k++) if (mem[k*16 + 7] !== exp_st[k]) bad_s++;
    chk(bad_s == 0, {tag, " R6 R7 status write-back (mismatches)"}, bad_s, 0);
  endtask

  initial begin
    int n0;
    void'($urandom(32'h5eed));
    for (int i = 0; i < 1024; i++) mem[i] = $urandom;
    for (int k = 0; k < 16; k++) put_desc(k, k, 32'h400, 1, 1'b1, 1'b1, 1'b1);
    rst_n = 1'b0; run = 1'b0; start = 1'b0; cur_desc = '0; tail_desc = '0;
    m_tready = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(idle === 1'b1 && m_tvalid === 1'b0 && mem_req === 1'b0 && frame_done === 1'b0,
        "R1 reset state", {idle, m_tvalid, mem_req, frame_done}, 4'b1000);

    // R2: start with run low is ignored
    put_desc(0, 0, 32'h400, 4, 1'b1, 1'b1, 1'b0);
    n0 = rx_n;
    pulse_start(0, 0);
    repeat (40) @(negedge clk);
    chk(idle === 1'b1 && rx_n == n0 && mem[7] == 32'h0, "R2 start ignored without run",
        {idle, mem[7][31]}, 2'b10);
    run = 1'b1;

    // single aligned descriptor, full throughput
    put_desc(0, 0, 32'h400, 8, 1'b1, 1'b1, 1'b0);
    run_walk(0, 0, 0, 1'b0, "single");

    // unaligned chain forming one frame, random back-pressure
    full_ready = 1'b0;
    put_desc(1, 2, 32'h501, 5, 1'b1, 1'b0, 1'b0);
    put_desc(2, 3, 32'h60a, 3, 1'b0, 1'b0, 1'b0);
    put_desc(3, 1, 32'h713, 7, 1'b0, 1'b1, 1'b0);
    run_walk(1, 3, 3, 1'b0, "unaligned chain");

    // R7: chain continues past the tail; the third descriptor must stay untouched
    put_desc(4, 5, 32'h803, 6, 1'b1, 1'b1, 1'b0);
    put_desc(5, 6, 32'h822, 6, 1'b1, 1'b1, 1'b0);
    put_desc(6, 4, 32'h841, 6, 1'b1, 1'b1, 1'b0);
    run_walk(4, 5, 5, 1'b0, "tail stop R7");

    // R3: already-complete descriptor in the middle, then start directly on it
    put_desc(7, 8, 32'h900, 9, 1'b1, 1'b1, 1'b0);
    put_desc(8, 9, 32'h920, 9, 1'b1, 1'b1, 1'b1);
    put_desc(9, 7, 32'h940, 9, 1'b1, 1'b1, 1'b0);
    run_walk(7, 9, 9, 1'b0, "complete in chain R3");
    run_walk(8, 9, 9, 1'b0, "start on complete R3");

    // R9: run dropped during the first descriptor
    put_desc(10, 11, 32'ha00, 40, 1'b1, 1'b1, 1'b0);
    put_desc(11, 12, 32'ha40, 40, 1'b1, 1'b1, 1'b0);
    put_desc(12, 10, 32'ha80, 40, 1'b1, 1'b1, 1'b0);
    run_walk(10, 12, 10, 1'b1, "run drop R9");

    // random chains
    for (int it = 0; it < 20; it++) begin
      int nd;
      nd = 1 + $urandom_range(3);
      full_ready = ($urandom_range(3) == 0);
      for (int k = 0; k < nd; k++)
        put_desc(k, (k + 1) % 16, 32'h400 + $urandom_range(32'hb00), 1 + $urandom_range(23),
                 k == 0, k == nd - 1, 1'b0);
      run_walk(0, nd - 1, nd - 1, 1'b0, "random");
    end

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule